// File: doc/BRIEF.md
# Serial Control Port Register File

This block receives write-only control traffic over a three-wire serial link: an active-low select, a serial clock and a serial data line. A single transaction is one 16-bit frame made of an 8-bit address and then an 8-bit data byte. The block decodes the frame into a bank of sixteen 8-bit control registers: channel volumes with mute, mixer path switches, a reset/power-down register and a microphone gain select. All sixteen registers are presented at once on a flat parallel output bus.

The three serial lines are brought into the system clock domain through multi-stage synchronizers. A rising edge seen on the synchronized serial clock shifts in one bit. The register write happens only after a complete frame has arrived. Only the low five address bits are decoded, so every register appears again in each 32-address window. Writes to unimplemented addresses are dropped. One reserved test address never changes a register, and it sets a sticky flag instead. Attenuation and gain codes are stored as written and are not interpreted.

Top module: `ctl_serial_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released with no frame received, slots 0 and 1 read 0x00 (unmuted, 0 dB), slots 2 to 7 read 0x80 (muted, 0 dB), slots 8 to 15 read 0x00, and `test_hit` is 0.
- R2: A frame is 16 rising edges of `ser_clk` while `ser_sel_n` is low, each bit MSB first, address byte before data byte. The addressed register changes only after the 16th edge. Slot `k` occupies `ctl_q[8k+7:8k]`. Decoded addresses 0x00–0x03 map to slots 0–3, 0x08–0x0B to slots 4–7, 0x10–0x16 to slots 8–14, and 0x19 to slot 15.
- R3: Address bits 7:5 are ignored, so for example address 0x20 writes slot 0 and 0xF9 writes slot 15.
- R4: A frame whose decoded address is not implemented leaves every slot unchanged.
- R5: A frame with decoded address 0x1A leaves every slot unchanged and sets `test_hit`, which then stays 1 until reset.
- R6: Volume slots 0–7 keep bit 7 (mute, 1 = muted) and bits 4:0 (attenuation, 00000 = 0 dB to 11111 = −62 dB in 2 dB steps). Bits 6:5 always read 0.
- R7: Mixer switch slots 8–13 keep the full data byte. Slot 14 (address 0x16) keeps only bits 1:0, the power-down and reset controls. Slot 15 (address 0x19) keeps only bit 0, the microphone gain select. All other bits of slots 14 and 15 read 0.
- R8: If `ser_sel_n` goes high before 16 bits have arrived, the partial frame is discarded. The next frame starts counting from bit one.
- R9: Serial clock edges after the 16th and before `ser_sel_n` goes high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads defaults |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ctl_q | output | 128 | Sixteen 8-bit register slots, slot k at bits 8k+7:8k |
| test_hit | output | 1 | Sticky flag, set by a write to decoded address 0x1A |

## Verification
Most internal faults appear on `ctl_q` about eight system clocks after the frame that should have caused a change. A bit counter that slips, or that is not cleared when select goes high, moves the frame boundary. The data then lands in a different slot or with its bits shifted. A faulty address decode or slot mapping writes the wrong slot, or writes a slot that should have been left alone. A faulty field mask leaves bits set that must read zero. The test flag is checked after the reserved write and again after later ordinary writes, because a flag that is not sticky only shows up after it has had time to fall.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
   localparam int ADDR_W   = 8;
   localparam int DATA_W   = 8;
   localparam int DEC_W    = 5;
   localparam int NUM_REGS = 16;
   localparam logic [DEC_W-1:0] TEST_ADDR = 5'h1A;

   // decoded address belonging to each slot
   function automatic logic [DEC_W-1:0] slot_addr(input int idx);
      if (idx < 4)       return DEC_W'(idx);
      else if (idx < 8)  return DEC_W'(idx + 4);
      else if (idx < 15) return DEC_W'(idx + 8);
      else               return DEC_W'(25);
   endfunction

   function automatic logic [DATA_W-1:0] slot_default(input int idx);
      return (idx >= 2 && idx < 8) ? 8'h80 : 8'h00;
   endfunction

   function automatic logic [DATA_W-1:0] slot_mask(input int idx);
      if (idx < 8)        return 8'h9F;
      else if (idx < 14)  return 8'hFF;
      else if (idx == 14) return 8'h03;
      else                return 8'h01;
   endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
   parameter int WIDTH   = 3,
   parameter int STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pipe[s] <= RST_VAL;
         else if (s == 0) pipe[s] <= d;
         else             pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctl_frame.sv
module ctl_frame
   import ctl_serial_pkg::*;
#(
   parameter int FRAME_BITS = ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sclk,
   input  logic              sdat,
   output logic              vld,
   output logic [DEC_W-1:0]  dec_addr,
   output logic [DATA_W-1:0] data
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam int SH_W  = DEC_W + DATA_W;

   if (FRAME_BITS != ADDR_W + DATA_W) begin : g_bad_frame
      $error("ctl_frame: FRAME_BITS must equal ADDR_W + DATA_W");
   end

   logic             sclk_d;
   logic             rise;
   logic [CNT_W-1:0] cnt;
   logic [SH_W-1:0]  shreg;

   assign rise = sclk & ~sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cnt    <= '0;
         shreg  <= '0;
         vld    <= 1'b0;
      end else begin
         sclk_d <= sclk;
         vld    <= 1'b0;
         if (!sel) begin
            cnt <= '0;
         end else if (rise && cnt < CNT_W'(FRAME_BITS)) begin
            // upper address bits fall off the top of the shifter
            shreg <= {shreg[SH_W-2:0], sdat};
            cnt   <= cnt + 1'b1;
            vld   <= (cnt == CNT_W'(FRAME_BITS - 1));
         end
      end
   end

   assign dec_addr = shreg[SH_W-1:DATA_W];
   assign data     = shreg[DATA_W-1:0];

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(FRAME_BITS));
   p_desel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (cnt == '0));
   p_vld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld);
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
   import ctl_serial_pkg::*;
(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             vld,
   input  logic [DEC_W-1:0]                 dec_addr,
   input  logic [DATA_W-1:0]                data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  q,
   output logic                             test_hit
);
   logic [NUM_REGS-1:0] wr_en;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      localparam logic [DEC_W-1:0]  ADDR = slot_addr(i);
      localparam logic [DATA_W-1:0] DEF  = slot_default(i);
      localparam logic [DATA_W-1:0] MSK  = slot_mask(i);

      assign wr_en[i] = vld && (dec_addr == ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q[i] <= DEF;
         else if (wr_en[i]) q[i] <= data & MSK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             test_hit <= 1'b0;
      else if (vld && dec_addr == TEST_ADDR)  test_hit <= 1'b1;
   end

   p_wr_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      test_hit |=> test_hit);
   p_test_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && dec_addr == TEST_ADDR) |=> $stable(q));
endmodule

// File: rtl/ctl_serial_regfile.sv
module ctl_serial_regfile
   import ctl_serial_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ser_sel_n,
   input  logic                         ser_clk,
   input  logic                         ser_dat,
   output logic [NUM_REGS*DATA_W-1:0]   ctl_q,
   output logic                         test_hit
);
   logic [2:0]              raw_s;
   logic                    sel_s, sclk_s, sdat_s;
   logic                    frm_vld;
   logic [DEC_W-1:0]        frm_addr;
   logic [DATA_W-1:0]       frm_data;
   logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;

   ctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_sel_n, ser_clk, ser_dat}),
      .q    (raw_s)
   );

   assign sel_s  = ~raw_s[2];
   assign sclk_s = raw_s[1];
   assign sdat_s = raw_s[0];

   ctl_frame i_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_s),
      .sclk    (sclk_s),
      .sdat    (sdat_s),
      .vld     (frm_vld),
      .dec_addr(frm_addr),
      .data    (frm_data)
   );

   ctl_bank i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (frm_vld),
      .dec_addr(frm_addr),
      .data    (frm_data),
      .q       (bank_q),
      .test_hit(test_hit)
   );

   assign ctl_q = bank_q;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> $stable(ctl_q));
   for (genvar v = 0; v < 8; v++) begin : g_vol_chk
      p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_q[v*DATA_W+6 -: 2] == 2'b00);
   end
endmodule

// File: tb/test_ctl_serial_regfile.sv
module test_ctl_serial_regfile;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_sel_n = 1'b1;
   logic         ser_clk = 1'b0;
   logic         ser_dat = 1'b0;
   logic [127:0] ctl_q;
   logic         test_hit;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_reg [16];
   logic       exp_hit = 1'b0;

   always #10 clk = ~clk;

   ctl_serial_regfile i_ctl_serial_regfile (
      .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .ctl_q(ctl_q), .test_hit(test_hit)
   );

   function automatic int slot_of(input logic [4:0] a);
      case (a)
         5'h00, 5'h01, 5'h02, 5'h03: return int'(a);
         5'h08, 5'h09, 5'h0A, 5'h0B: return int'(a) - 4;
         5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h16: return int'(a) - 8;
         5'h19: return 15;
         default: return -1;
      endcase
   endfunction

   function automatic logic [7:0] keep_of(input int s);
      if (s < 8)   return 8'h9F;
      if (s < 14)  return 8'hFF;
      if (s == 14) return 8'h03;
      return 8'h01;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < 16; s++) exp_reg[s] = (s >= 2 && s < 8) ? 8'h80 : 8'h00;
      exp_hit = 1'b0;
   endtask

   task automatic model_write(input logic [7:0] a, input logic [7:0] d);
      int s;
      s = slot_of(a[4:0]);
      if (s >= 0) exp_reg[s] = d & keep_of(s);
      if (a[4:0] == 5'h1A) exp_hit = 1'b1;
   endtask

   task automatic check_all(input string req);
      @(negedge clk);
      for (int s = 0; s < 16; s++) begin
         checks++;
         if (ctl_q[s*8 +: 8] !== exp_reg[s]) begin
            failures++;
            $display("FAIL %s slot %0d actual=%02h expected=%02h", req, s,
                     ctl_q[s*8 +: 8], exp_reg[s]);
         end
      end
      checks++;
      if (test_hit !== exp_hit) begin
         failures++;
         $display("FAIL %s test_hit actual=%b expected=%b", req, test_hit, exp_hit);
      end
   endtask

   // shift n bits of w (MSB first) inside one select window
   task automatic send_bits(input logic [19:0] w, input int n);
      @(negedge clk);
      ser_sel_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         ser_dat = w[19-i];
         repeat (4) @(negedge clk);
         ser_clk = 1'b1;
         repeat (4) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (4) @(negedge clk);
      ser_sel_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic write_frame(input logic [7:0] a, input logic [7:0] d, input string req);
      send_bits({a, d, 4'h0}, 16);
      model_write(a, d);
      check_all(req);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1 during reset");
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_all("R1 after reset");

      write_frame(8'h00, 8'h95, "R2 R6 master left");
      write_frame(8'h0B, 8'hFF, "R2 R6 aux right");
      write_frame(8'h12, 8'hA5, "R2 R7 mixer");
      write_frame(8'h16, 8'hFF, "R7 power reg");
      write_frame(8'h19, 8'hFE, "R7 mic gain bit0 clear");
      write_frame(8'h19, 8'h01, "R7 mic gain bit0 set");
      write_frame(8'h21, 8'h1F, "R3 alias 0x21");
      write_frame(8'hF9, 8'h00, "R3 alias 0xF9");
      write_frame(8'h05, 8'hFF, "R4 unmapped 0x05");
      write_frame(8'h1F, 8'hFF, "R4 unmapped 0x1F");
      write_frame(8'h1A, 8'hFF, "R5 test address");
      write_frame(8'h03, 8'h42, "R5 flag stays set");

      // R8: partial frame of 7 bits aimed at slot 2, then deselect
      send_bits({8'h02, 8'h11, 4'h0}, 7);
      check_all("R8 partial discarded");
      write_frame(8'h09, 8'h8C, "R8 fresh frame after partial");

      // R9: 20 clocks in one window, only the first 16 count
      send_bits({8'h10, 8'h3C, 4'hF}, 20);
      model_write(8'h10, 8'h3C);
      check_all("R9 extra clocks ignored");

      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R1 re-reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule